// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status byte of a small 8-bit processor core. Four arithmetic flags (carry, half carry, zero, overflow) come from the ALU. Each flag arrives as a value with its own update strobe, so an instruction changes only the flags it defines. The carry follows the no-borrow convention: a subtract that does not borrow sets it. Rotate-through-carry results arrive on the same carry input. The half carry is the carry out of the low nibble on an add, or the absence of a borrow into the low nibble on a subtract. Overflow is set when the carry into the top bit differs from the carry out of it. Zero reports an all-zero result. The ALU computes these values and this block stores them.

Two power-management flags sit beside them: a power-down flag and a watchdog-expiry flag. Only discrete events change them: power-up reset, a clear-watchdog instruction, a halt instruction and a watchdog time-out. A register-file write to the status address loads the arithmetic flags but never these two. A read returns the whole byte.

Top module: `status_flag_reg`

## Requirements
- R1: `rd_data` shows carry at bit 0, half carry at bit 1, zero at bit 2, overflow at bit 3, power-down at bit 4 and watchdog-expiry at bit 5. Bits 7 and 6 always read 0.
- R2: A cycle with `rst` high clears all six flags, so `rd_data` is 0x00 after that edge.
- R3: A cycle with `wr_en` high loads bits 3:0 of `rd_data` from `wr_data[3:0]` at the next edge.
- R4: `wr_data[7:4]` has no effect: a write leaves power-down and watchdog-expiry unchanged.
- R5: With no write, a high bit of `alu_flag_upd` loads the same bit of `alu_flag_val` into the flag at the same `rd_data` position (bit 0 carry, bit 1 half carry, bit 2 zero, bit 3 overflow).
- R6: An arithmetic flag with neither a write nor its strobe keeps its value.
- R7: When a write and an ALU strobe fall in the same cycle, the write value wins for all four arithmetic flags.
- R8: `halt` sets power-down. `clr_wdt` without `halt` clears it. When both arrive in one cycle, `halt` wins.
- R9: `wdt_timeout` sets watchdog-expiry, even when `clr_wdt` or `halt` arrives in the same cycle.
- R10: `clr_wdt` or `halt` without `wdt_timeout` clears watchdog-expiry.
- R11: With none of `clr_wdt`, `halt` or `wdt_timeout`, both power flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wr_en | input | 1 | Register-file write strobe for the status address |
| wr_data | input | 8 | Write data; only bits 3:0 are used |
| alu_flag_val | input | 4 | New arithmetic flag values from the ALU |
| alu_flag_upd | input | 4 | Per-flag update strobes from the ALU |
| clr_wdt | input | 1 | Clear-watchdog instruction event |
| halt | input | 1 | Halt instruction event |
| wdt_timeout | input | 1 | Watchdog time-out event |
| rd_data | output | 8 | Current status byte |

## Verification
The read port shows the register directly, with no intervening stage. A wrong flag therefore appears on `rd_data` in the cycle after the edge that stored it, and stays there until a later event rewrites that flag. Power flags are rewritten only by rare events, so a wrong power flag persists long enough to be caught on the very next sample. A protection fault, where a write reaches bits 5:4, shows up as soon as a write carries upper data that differs from those flags. A precedence fault shows up only in cycles where two competing sources coincide. For that reason the stimulus forces such collisions often.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
    localparam int STAT_W     = 8;
    localparam int ARITH_N    = 4;
    localparam int POS_C      = 0;
    localparam int POS_AC     = 1;
    localparam int POS_Z      = 2;
    localparam int POS_OV     = 3;
    localparam int POS_PDF    = 4;
    localparam int POS_TO     = 5;
    localparam int PAD_W      = STAT_W - ARITH_N - 2;

    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } arith_flags_t;

    typedef struct packed {
        logic clr_wdt;
        logic halt;
        logic timeout;
    } pm_event_t;

    typedef struct packed {
        logic to;
        logic pdf;
    } pm_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(arith_flags_t a, pm_flags_t p);
        logic [STAT_W-1:0] s;
        s = '0;
        s[POS_C]   = a.c;
        s[POS_AC]  = a.ac;
        s[POS_Z]   = a.z;
        s[POS_OV]  = a.ov;
        s[POS_PDF] = p.pdf;
        s[POS_TO]  = p.to;
        return s;
    endfunction
endpackage

// File: rtl/status_arith_flags.sv
module status_arith_flags
    import status_flag_pkg::*;
#(
    parameter int N = ARITH_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] upd,
    input  logic [N-1:0] val,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (wr_en)
                q <= wr_bits[i];
            else if (upd[i])
                q <= val[i];
        end
        assign flags[i] = q;
    end
endmodule

// File: rtl/status_power_flags.sv
module status_power_flags
    import status_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pm_event_t ev,
    output pm_flags_t flags
);
    pm_flags_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (ev.halt)
                q.pdf <= 1'b1;
            else if (ev.clr_wdt)
                q.pdf <= 1'b0;

            if (ev.timeout)
                q.to <= 1'b1;
            else if (ev.clr_wdt || ev.halt)
                q.to <= 1'b0;
        end
    end

    assign flags = q;
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import status_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [ARITH_N-1:0] alu_flag_val,
    input  logic [ARITH_N-1:0] alu_flag_upd,
    input  logic              clr_wdt,
    input  logic              halt,
    input  logic              wdt_timeout,
    output logic [STAT_W-1:0] rd_data
);
    logic [ARITH_N-1:0] arith_q;
    arith_flags_t       arith_s;
    pm_event_t          pm_ev;
    pm_flags_t          pm_q;
    logic               unused_wr_hi;

    assign unused_wr_hi = ^wr_data[STAT_W-1:ARITH_N];

    status_arith_flags #(.N(ARITH_N)) u_arith (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bits (wr_data[ARITH_N-1:0]),
        .upd     (alu_flag_upd),
        .val     (alu_flag_val),
        .flags   (arith_q)
    );

    assign pm_ev = '{clr_wdt: clr_wdt, halt: halt, timeout: wdt_timeout};

    status_power_flags u_power (
        .clk   (clk),
        .rst   (rst),
        .ev    (pm_ev),
        .flags (pm_q)
    );

    assign arith_s = arith_flags_t'(arith_q);
    assign rd_data = pack_status(arith_s, pm_q);
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [3:0] alu_flag_val,
    input logic [3:0] alu_flag_upd,
    input logic       clr_wdt,
    input logic       halt,
    input logic       wdt_timeout,
    input logic [7:0] rd_data
);
    logic started;
    always_ff @(posedge clk) started <= 1'b1;

    p_pad_zero_r1: assert property (@(posedge clk) disable iff (!started)
        rd_data[7:6] == 2'b00);

    p_reset_clear_r2: assert property (@(posedge clk)
        rst |=> rd_data == 8'h00);

    p_write_load_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[3:0] == $past(wr_data[3:0]));

    p_write_protect_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_wdt && !halt && !wdt_timeout) |=> $stable(rd_data[5:4]));

    p_alu_load_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((rd_data[3:0] ^ $past(alu_flag_val)) & $past(alu_flag_upd)) == 4'b0000);

    p_arith_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && alu_flag_upd == 4'b0000) |=> $stable(rd_data[3:0]));

    p_write_beats_alu_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && alu_flag_upd != 4'b0000) |=> rd_data[3:0] == $past(wr_data[3:0]));

    p_halt_sets_pdf_r8: assert property (@(posedge clk) disable iff (rst)
        halt |=> rd_data[4]);

    p_clr_clears_pdf_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_wdt && !halt) |=> !rd_data[4]);

    p_timeout_sets_to_r9: assert property (@(posedge clk) disable iff (rst)
        wdt_timeout |=> rd_data[5]);

    p_event_clears_to_r10: assert property (@(posedge clk) disable iff (rst)
        ((clr_wdt || halt) && !wdt_timeout) |=> !rd_data[5]);

    p_power_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!clr_wdt && !halt && !wdt_timeout) |=> $stable(rd_data[5:4]));
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .alu_flag_val (alu_flag_val),
    .alu_flag_upd (alu_flag_upd),
    .clr_wdt      (clr_wdt),
    .halt         (halt),
    .wdt_timeout  (wdt_timeout),
    .rd_data      (rd_data)
);

// File: tb/tb_status_flag_reg.sv
module tb_status_flag_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [3:0] alu_flag_val;
    logic [3:0] alu_flag_upd;
    logic       clr_wdt;
    logic       halt;
    logic       wdt_timeout;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] model = 8'h00;

    always #4 clk = ~clk;

    status_flag_reg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .alu_flag_val(alu_flag_val), .alu_flag_upd(alu_flag_upd),
        .clr_wdt(clr_wdt), .halt(halt), .wdt_timeout(wdt_timeout),
        .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Independent reference of the requirements
    function automatic logic [7:0] next_model(logic [7:0] cur, logic r, logic we, logic [7:0] wd,
                                              logic [3:0] v, logic [3:0] u,
                                              logic cw, logic h, logic to);
        logic [7:0] n;
        if (r) return 8'h00;                              // R2
        n = cur;
        for (int i = 0; i < 4; i++) begin
            if (we) n[i] = wd[i];                         // R3, R7
            else if (u[i]) n[i] = v[i];                   // R5
        end
        if (h) n[4] = 1'b1;                               // R8
        else if (cw) n[4] = 1'b0;
        if (to) n[5] = 1'b1;                              // R9
        else if (cw || h) n[5] = 1'b0;                    // R10
        n[7:6] = 2'b00;                                   // R1
        return n;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(logic r, logic we, logic [7:0] wd, logic [3:0] v, logic [3:0] u,
                        logic cw, logic h, logic to);
        string ar, pr;
        rst = r; wr_en = we; wr_data = wd; alu_flag_val = v; alu_flag_upd = u;
        clr_wdt = cw; halt = h; wdt_timeout = to;
        model = next_model(model, r, we, wd, v, u, cw, h, to);
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            check("R2", rd_data, model);
        end else begin
            ar = we ? (u != 0 ? "R7" : "R3") : (u != 0 ? "R5" : "R6");
            pr = to ? "R9" : (h ? "R8" : (cw ? "R10" : (we ? "R4" : "R11")));
            check(ar, {4'h0, rd_data[3:0]}, {4'h0, model[3:0]});
            check(pr, {6'h0, rd_data[5:4]}, {6'h0, model[5:4]});
            check("R1", {6'h0, rd_data[7:6]}, 8'h00);
        end
    endtask

    initial begin
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        rst = 1'b1; wr_en = 0; wr_data = 0; alu_flag_val = 0; alu_flag_upd = 0;
        clr_wdt = 0; halt = 0; wdt_timeout = 0;
        @(negedge clk);
        step(1, 0, 8'h00, 4'h0, 4'h0, 0, 0, 0);                 // R2 reset state
        // Directed corners
        step(0, 0, 8'h00, 4'h0, 4'h0, 0, 1, 1);                 // R8 set PDF, R9 set TO
        step(0, 1, 8'hCF, 4'h0, 4'h0, 0, 0, 0);                 // R4: upper bits 00 ignored
        step(0, 1, 8'h00, 4'h0, 4'h0, 0, 0, 0);                 // R3 clear, R4 keeps 11
        step(0, 1, 8'h0A, 4'h5, 4'hF, 0, 0, 0);                 // R7 write wins
        step(0, 0, 8'hFF, 4'h5, 4'h3, 0, 0, 0);                 // R5 partial update
        step(0, 0, 8'h00, 4'h0, 4'h0, 0, 0, 0);                 // R6, R11 hold
        step(0, 0, 8'h00, 4'h0, 4'h0, 1, 0, 0);                 // R8 clear PDF, R10 clear TO
        step(0, 0, 8'h00, 4'h0, 4'h0, 0, 0, 1);                 // R9
        step(0, 0, 8'h00, 4'h0, 4'h0, 1, 1, 0);                 // R8 halt wins, R10 clears TO
        step(0, 1, 8'h30, 4'h0, 4'h0, 0, 0, 0);                 // R4 write of 1s to 5:4 ignored
        step(0, 0, 8'h00, 4'h0, 4'h0, 1, 0, 1);                 // R9 timeout over clear
        step(1, 1, 8'hFF, 4'hF, 4'hF, 1, 1, 1);                 // R2 reset beats all
        // Constrained random with frequent collisions
        for (int n = 0; n < 3000; n++) begin
            logic r, we, cw, h, to;
            r  = ($urandom_range(0, 99) < 2);
            we = ($urandom_range(0, 99) < 35);
            cw = ($urandom_range(0, 99) < 20);
            h  = ($urandom_range(0, 99) < 20);
            to = ($urandom_range(0, 99) < 15);
            step(r, we, 8'($urandom()), 4'($urandom()), 4'($urandom()), cw, h, to);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule